// File: doc/BRIEF.md
# Saturating Two-Tap FIR Filter

This block filters a stream of unsigned samples with the fixed two-tap response y[n] = 4·x[n] + 3·x[n−1] and clamps the result into a non-negative range. Samples arrive one at a time under a four-phase request/acknowledge exchange. The producer places a sample on `sample_i` and raises `start_i`. The block computes, raises `done_o` with the result on `res_o`, and keeps both steady until the producer lowers `start_i`. The block then lowers `done_o` and becomes ready for the next sample.

The work is done in a fixed order. The sample is captured first. The accumulator is then loaded with four times the sample plus the stored tap. After that, the tap register is overwritten with three times the same sample, so the next sample sees it as its previous-sample term. Last, the accumulator is clamped and moved to the output. All arithmetic wraps at `DW` bits before the clamp is applied.

Top module: `sat_fir2`

## Requirements
- R1: After a synchronous active-high reset, `done_o` is 0, `res_o` is 0 and the stored tap is 0. The first result after reset is therefore the clamp of 4·x alone.
- R2: While the block is idle and `start_i` is low, `res_o` and `done_o` do not change, whatever `sample_i` does.
- R3: The unclamped value is (4·x[n] + T) mod 2^DW. T = (3·x[n−1]) mod 2^DW, where x[n−1] is the previously accepted sample.
- R4: If bit DW−1 of the unclamped value is 1, `res_o` is 0.
- R5: If bit DW−1 is 0 and bit DW−2 is 1, `res_o` is 2^(DW−2)−1 (0x3F for DW=8).
- R6: If bits DW−1 and DW−2 are both 0, `res_o` equals the unclamped value.
- R7: `done_o` rises on the 4th rising clock edge counted from the edge that first samples `start_i` high while idle. `res_o` holds the new result from that same edge.
- R8: While `done_o` is high, `res_o` is stable. `done_o` stays high while `start_i` stays high, and it falls on the first edge that samples `start_i` low.
- R9: `sample_i` is captured on the accepting edge. Later changes during the computation or while `done_o` is high have no effect on the result or the stored tap.
- R10: Holding `start_i` high after `done_o` rises does not begin another computation. A new sample is accepted only after `done_o` has returned to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request: sample valid, start a computation |
| sample_i | input | DW | Unsigned input sample |
| res_o | output | DW | Clamped filter output, registered |
| done_o | output | 1 | Acknowledge: result valid |

## Verification
The bench builds the block with its default width, DW = 8. At that width the whole input space is small, so every one of the 256 sample values is sent twice. The first pass uses ascending order and the second uses a scattered order. Across the two passes many different previous-sample taps are paired with each new sample, and all three clamp branches are hit many times, including the wrap of the 8-bit sum. Each exchange also moves `sample_i` during the computation and during the hold phase, and keeps `start_i` high for several cycles. This exercises capture, result stability and the rule against restarting.

// File: rtl/sat_fir2_pkg.sv
package sat_fir2_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_TAP,
    ST_SAT,
    ST_HOLD
  } fir_state_e;

endpackage

// File: rtl/sat_fir2_clamp.sv
module sat_fir2_clamp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] raw_i,
  output logic [DW-1:0] clamped_o
);
  localparam logic [DW-1:0] CLAMP_HI = {2'b00, {(DW-2){1'b1}}};

  always_comb begin
    if (raw_i[DW-1])      clamped_o = '0;
    else if (raw_i[DW-2]) clamped_o = CLAMP_HI;
    else                  clamped_o = raw_i;
  end
endmodule

// File: rtl/sat_fir2_ctrl.sv
module sat_fir2_ctrl
  import sat_fir2_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic cap_en_o,
  output logic acc_en_o,
  output logic tap_en_o,
  output logic out_en_o,
  output logic done_o
);
  fir_state_e state_q, state_d;
  logic       done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ACC;
      ST_ACC:  state_d = ST_TAP;
      ST_TAP:  state_d = ST_SAT;
      ST_SAT:  state_d = ST_HOLD;
      ST_HOLD: if (!start_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SAT)                      done_q <= 1'b1;
      else if (state_q == ST_HOLD && !start_i)    done_q <= 1'b0;
    end
  end

  assign cap_en_o = (state_q == ST_IDLE) && start_i;
  assign acc_en_o = (state_q == ST_ACC);
  assign tap_en_o = (state_q == ST_TAP);
  assign out_en_o = (state_q == ST_SAT);
  assign done_o   = done_q;

  // R2: idle with no request stays idle and silent
  a_r2_idle_wait: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE && !done_q));

  // R7: leaving the clamp step raises the acknowledge
  a_r7_done_rises: assert property (@(posedge clk) disable iff (rst)
    out_en_o |=> done_q);

  // R8, R10: acknowledge held while request held
  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done_q && start_i) |=> (done_q && state_q == ST_HOLD));

  // R8: acknowledge released once request drops
  a_r8_done_clears: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start_i) |=> !done_q);
endmodule

// File: rtl/sat_fir2_dp.sv
module sat_fir2_dp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sample_i,
  input  logic          cap_en_i,
  input  logic          acc_en_i,
  input  logic          tap_en_i,
  input  logic          out_en_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] sample_q, acc_q, tap_q, res_q;
  logic [DW-1:0] times4, times3, clamped;

  assign times4 = {sample_q[DW-3:0], 2'b00};
  assign times3 = {sample_q[DW-2:0], 1'b0} + sample_q;

  sat_fir2_clamp #(.DW(DW)) u_clamp (
    .raw_i     (acc_q),
    .clamped_o (clamped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= '0;
      acc_q    <= '0;
      tap_q    <= '0;
      res_q    <= '0;
    end else begin
      if (cap_en_i) sample_q <= sample_i;
      if (acc_en_i) acc_q    <= times4 + tap_q;
      if (tap_en_i) tap_q    <= times3;
      if (out_en_i) res_q    <= clamped;
    end
  end

  assign res_o = res_q;

  // R4, R5: a clamped output never has either of the two top bits set
  a_r5_below_clamp: assert property (@(posedge clk) disable iff (rst)
    res_q[DW-1:DW-2] == 2'b00);
endmodule

// File: rtl/sat_fir2.sv
module sat_fir2 #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [DW-1:0] sample_i,
  output logic [DW-1:0] res_o,
  output logic          done_o
);
  logic cap_en, acc_en, tap_en, out_en;

  sat_fir2_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .cap_en_o (cap_en),
    .acc_en_o (acc_en),
    .tap_en_o (tap_en),
    .out_en_o (out_en),
    .done_o   (done_o)
  );

  sat_fir2_dp #(.DW(DW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .sample_i (sample_i),
    .cap_en_i (cap_en),
    .acc_en_i (acc_en),
    .tap_en_i (tap_en),
    .out_en_i (out_en),
    .res_o    (res_o)
  );

  // R8: result is frozen while acknowledged
  a_r8_res_stable: assert property (@(posedge clk) disable iff (rst)
    done_o |=> $stable(res_o));
endmodule

// File: tb/sim_sat_fir2.sv
module sim_sat_fir2;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic [DW-1:0] res_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int prev   = 0;

  always #10 clk = ~clk;

  sat_fir2 #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i),
    .sample_i(sample_i), .res_o(res_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int s, input int p, output string tag);
    int raw;
    raw = (4 * s + ((3 * p) & 255)) & 255;
    if (raw[7]) begin tag = "R4"; return 0; end
    if (raw[6]) begin tag = "R5"; return 63; end
    tag = "R6";
    return raw;
  endfunction

  task automatic transact(input int s);
    int    n, expv;
    string tag;
    expv = model(s, prev, tag);
    @(negedge clk);
    sample_i = s[DW-1:0];
    start_i  = 1'b1;
    n = 0;
    while (!done_o && n < 40) begin
      @(posedge clk); @(negedge clk);
      n++;
      sample_i = ~sample_i;                       // R9: scramble after capture
    end
    chk(n == 4, "R7 latency", n, 4);
    chk(res_o == expv[DW-1:0], {"R3 ", tag, " result"}, res_o, expv);
    for (int k = 0; k < 3; k++) begin             // R10: request held high
      @(posedge clk); @(negedge clk);
      sample_i = sample_i + 8'd29;
      chk(done_o == 1'b1, "R10 done held", done_o, 1);
      chk(res_o == expv[DW-1:0], "R8 res stable", res_o, expv);
    end
    start_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(done_o == 1'b0, "R8 done clears", done_o, 0);
    chk(res_o == expv[DW-1:0], "R8 res kept", res_o, expv);
    prev = s;
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<200000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    chk(res_o == '0, "R1 reset res", res_o, 0);
    for (int k = 0; k < 6; k++) begin              // R2: idle, no request
      sample_i = 8'(k * 53 + 7);
      @(posedge clk); @(negedge clk);
      chk(done_o == 1'b0, "R2 idle done", done_o, 0);
      chk(res_o == '0, "R2 idle res", res_o, 0);
    end
    prev = 0;                                      // R1: tap starts at zero
    for (int i = 0; i < 256; i++) transact(i);
    for (int i = 0; i < 256; i++) transact((i * 37 + 11) & 255);
    transact(255); transact(255); transact(0); transact(16); transact(15);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule